// File: doc/BRIEF.md
# Interrupt IN Endpoint Transmit Buffer

This block holds the single outgoing packet of an interrupt IN endpoint, at most eight bytes. The processor writes the packet one byte at a time. A commit strobe then locks the packet and records its length. On an IN token from the host, the USB side reads the locked bytes out in the order they were written. When no packet is locked, the token is answered with a one-cycle NAK indication.

After the last byte is read out, the block waits for the handshake. If the host acknowledges, a completion flag is set, the flag raises an interrupt request for as long as it stays set, and the buffer empties for the next packet. If the host does not acknowledge, the packet stays locked and goes out again on the next token. A software clear throws away pending data at any time. A write-one strobe clears the completion flag.

The controller is a four-state machine. `FILL` takes processor writes. `ARMED` holds a locked packet and waits for a token. `SEND` streams bytes. `WAIT_HS` waits for the host handshake. The transitions are:
- commit: `FILL` to `ARMED`
- token with data: `ARMED` to `SEND`
- token with an empty packet: `ARMED` to `WAIT_HS`
- last byte read: `SEND` to `WAIT_HS`
- ack: `WAIT_HS` to `FILL`
- miss: `WAIT_HS` to `ARMED`
- clear: any state to `FILL`

Top module: `intr_in_buffer`

## Requirements
- R1: Reset leaves the block in `FILL` with `tx_valid`, `nak`, `pkt_armed` and `done_irq` all low.
- R2: In `FILL`, writes are stored in order up to eight bytes, and further writes are dropped. At commit, `tx_len` shows the number of bytes stored (0 to 8). A write in the same cycle as a commit is not stored.
- R3: A commit in `FILL` moves the block to `ARMED`, and `pkt_armed` goes high in the next cycle.
- R4: An IN token sampled in `FILL` raises `nak` for exactly the following cycle, and no data is presented.
- R5: An IN token sampled in `ARMED` with a non-empty packet puts the first byte on `tx_data` with `tx_valid` high from the next cycle. Each cycle with `tx_rd` high advances to the next byte, and `tx_last` marks the final byte. After that byte is read, `tx_valid` is low.
- R6: An IN token on a zero-length packet goes straight to `WAIT_HS`, and `tx_valid` never rises.
- R7: `host_ack` in `WAIT_HS` sets the completion flag and returns the block to `FILL` with the buffer empty, one cycle later.
- R8: `host_miss` in `WAIT_HS` returns the block to `ARMED` with the packet intact, so that the next token resends the same bytes.
- R9: While the block is not in `FILL`, processor writes and commits have no effect on the locked packet or on `tx_len`.
- R10: `buf_clear` forces `FILL` from any state in one cycle and discards stored bytes. It leaves the completion flag unchanged.
- R11: `done_irq` is high exactly while the completion flag is set. `done_clr` clears the flag, and a set in the same cycle as `done_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Byte write strobe from the processor |
| cpu_wdata | input | 8 | Byte written |
| pkt_commit | input | 1 | Locks the written bytes as one packet |
| buf_clear | input | 1 | Discards pending data, forces `FILL` |
| done_clr | input | 1 | Write-one clear of the completion flag |
| in_token | input | 1 | IN token addressed to this endpoint |
| tx_rd | input | 1 | USB side consumes the presented byte |
| host_ack | input | 1 | Host returned ACK for the sent packet |
| host_miss | input | 1 | No ACK arrived for the sent packet |
| tx_valid | output | 1 | A packet byte is presented |
| tx_data | output | 8 | Presented packet byte |
| tx_last | output | 1 | Presented byte is the final one |
| tx_len | output | 4 | Length of the locked packet |
| nak | output | 1 | One-cycle NAK answer to a token |
| pkt_armed | output | 1 | A packet is locked (not in `FILL`) |
| done_irq | output | 1 | Completion flag / interrupt request |

## Verification
The send path is tested with several packets:
- a short three-byte packet, which checks byte order and the placement of `tx_last`;
- an over-full burst of ten writes, which shows that the store stops at eight;
- a zero-length packet, which shows the direct jump to `WAIT_HS` with no data.

The same three-byte packet is sent again after a missed handshake, which separates resending from refilling. Writes and commits made while a packet is locked, a clear while armed, and `done_clr` in the same cycle as an ACK each show whether a lower-priority input leaks through. Tokens on an empty or cleared buffer check the NAK path.

// File: rtl/intr_in_pkg.sv
`timescale 1ns/1ps
package intr_in_pkg;

    typedef enum logic [1:0] {
        S_FILL    = 2'd0,
        S_ARMED   = 2'd1,
        S_SEND    = 2'd2,
        S_WAIT_HS = 2'd3
    } ibuf_state_t;

endpackage

// File: rtl/intr_in_store.sv
`timescale 1ns/1ps
module intr_in_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              level_clr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  level
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              room;

    assign room    = (level < CNT_W'(DEPTH));
    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n || level_clr) begin
            level <= '0;
        end else if (wr_ok && room) begin
            level <= level + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok && room && !level_clr) begin
            mem[level[IDX_W-1:0]] <= wr_data;
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && !level_clr && level == CNT_W'(DEPTH)) |=> (level == CNT_W'(DEPTH)));

endmodule

// File: rtl/intr_in_flag.sv
`timescale 1ns/1ps
module intr_in_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_i) begin
            flag <= 1'b1;
        end else if (clr_i) begin
            flag <= 1'b0;
        end
    end

    // R11
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag);

    // R11
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag);

endmodule

// File: rtl/intr_in_ctrl.sv
`timescale 1ns/1ps
module intr_in_ctrl
    import intr_in_pkg::*;
#(
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic             commit,
    input  logic             clear,
    input  logic             in_token,
    input  logic             tx_rd,
    input  logic             host_ack,
    input  logic             host_miss,
    input  logic [CNT_W-1:0] level,
    output logic             wr_ok,
    output logic             level_clr,
    output logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] pkt_len,
    output logic             tx_valid,
    output logic             tx_last,
    output logic             nak,
    output logic             pkt_armed,
    output logic             set_done
);

    ibuf_state_t     state;
    ibuf_state_t     state_nx;
    logic [CNT_W-1:0] rptr;
    logic             at_end;

    assign at_end = (rptr == pkt_len - CNT_W'(1));
    assign rd_idx = rptr[IDX_W-1:0];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_FILL;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_FILL: begin
                if (commit) state_nx = S_ARMED;
            end
            S_ARMED: begin
                if (in_token) begin
                    state_nx = (pkt_len == '0) ? S_WAIT_HS : S_SEND;
                end
            end
            S_SEND: begin
                if (tx_rd && at_end) state_nx = S_WAIT_HS;
            end
            S_WAIT_HS: begin
                if (host_ack)       state_nx = S_FILL;
                else if (host_miss) state_nx = S_ARMED;
            end
        endcase
        if (clear) state_nx = S_FILL;
    end

    // outputs
    always_comb begin
        wr_ok     = 1'b0;
        level_clr = clear;
        tx_valid  = 1'b0;
        tx_last   = 1'b0;
        pkt_armed = 1'b1;
        set_done  = 1'b0;
        unique case (state)
            S_FILL: begin
                pkt_armed = 1'b0;
                wr_ok     = wr_req && !commit && !clear;
            end
            S_ARMED: begin
            end
            S_SEND: begin
                tx_valid = 1'b1;
                tx_last  = at_end;
            end
            S_WAIT_HS: begin
                if (host_ack) begin
                    level_clr = 1'b1;
                    set_done  = !clear;
                end
            end
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr    <= '0;
            pkt_len <= '0;
            nak     <= 1'b0;
        end else begin
            nak <= in_token && (state == S_FILL);
            if (state == S_FILL && commit && !clear) begin
                pkt_len <= level;
            end
            if (state != S_SEND) begin
                rptr <= '0;
            end else if (tx_rd) begin
                rptr <= rptr + CNT_W'(1);
            end
        end
    end

    // R4
    nak_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_token && state == S_FILL) |=> (nak && !tx_valid));

    // R5
    read_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (rptr < pkt_len));

    // R6
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARMED && in_token && pkt_len == '0 && !clear) |=> (state == S_WAIT_HS));

    // R7
    ack_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_HS && host_ack && !clear) |=> (state == S_FILL && level == '0));

    // R8
    miss_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_HS && !host_ack && host_miss && !clear) |=> (state == S_ARMED && $stable(pkt_len)));

    // R9
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_FILL) |=> $stable(pkt_len));

    // R10
    clear_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (state == S_FILL && level == '0));

endmodule

// File: rtl/intr_in_buffer.sv
`timescale 1ns/1ps
module intr_in_buffer #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              pkt_commit,
    input  logic              buf_clear,
    input  logic              done_clr,
    input  logic              in_token,
    input  logic              tx_rd,
    input  logic              host_ack,
    input  logic              host_miss,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_last,
    output logic [CNT_W-1:0]  tx_len,
    output logic              nak,
    output logic              pkt_armed,
    output logic              done_irq
);

    logic             wr_ok;
    logic             level_clr;
    logic [IDX_W-1:0] rd_idx;
    logic [CNT_W-1:0] level;
    logic             set_done;

    intr_in_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (cpu_wr),
        .commit    (pkt_commit),
        .clear     (buf_clear),
        .in_token  (in_token),
        .tx_rd     (tx_rd),
        .host_ack  (host_ack),
        .host_miss (host_miss),
        .level     (level),
        .wr_ok     (wr_ok),
        .level_clr (level_clr),
        .rd_idx    (rd_idx),
        .pkt_len   (tx_len),
        .tx_valid  (tx_valid),
        .tx_last   (tx_last),
        .nak       (nak),
        .pkt_armed (pkt_armed),
        .set_done  (set_done)
    );

    intr_in_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ok     (wr_ok),
        .wr_data   (cpu_wdata),
        .level_clr (level_clr),
        .rd_idx    (rd_idx),
        .rd_data   (tx_data),
        .level     (level)
    );

    intr_in_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_done),
        .clr_i (done_clr),
        .flag  (done_irq)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!tx_valid && !nak && !pkt_armed && !done_irq));

endmodule

// File: tb/intr_in_buffer_test.sv
`timescale 1ns/1ps
module intr_in_buffer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic       pkt_commit = 1'b0;
    logic       buf_clear = 1'b0;
    logic       done_clr = 1'b0;
    logic       in_token = 1'b0;
    logic       tx_rd = 1'b0;
    logic       host_ack = 1'b0;
    logic       host_miss = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_last;
    logic [3:0] tx_len;
    logic       nak;
    logic       pkt_armed;
    logic       done_irq;

    int         checks = 0;
    int         fails = 0;
    logic [7:0] sbq[$];
    logic [7:0] model[$];

    always #2 clk = ~clk;

    intr_in_buffer uut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .pkt_commit(pkt_commit), .buf_clear(buf_clear), .done_clr(done_clr),
        .in_token(in_token), .tx_rd(tx_rd), .host_ack(host_ack), .host_miss(host_miss),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_len(tx_len),
        .nak(nak), .pkt_armed(pkt_armed), .done_irq(done_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a byte is consumed
    always @(negedge clk) begin
        logic [7:0] e;
        if (rst_n && tx_valid && tx_rd) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R5/R6 unexpected byte", tx_data, -1);
            end else begin
                e = sbq.pop_front();
                chk(tx_data == e, "R5 byte order", tx_data, e);
                chk(tx_last == (sbq.size() == 0), "R5 last marker", tx_last, sbq.size() == 0);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_byte(input logic [7:0] b, input bit keep);
        cpu_wr = 1'b1;
        cpu_wdata = b;
        if (keep) model.push_back(b);
        step();
        cpu_wr = 1'b0;
    endtask

    task automatic do_commit();
        pkt_commit = 1'b1; step(); pkt_commit = 1'b0;
    endtask

    task automatic do_token();
        in_token = 1'b1; step(); in_token = 1'b0;
    endtask

    task automatic do_ack(input bit with_clr);
        host_ack = 1'b1; done_clr = with_clr; step(); host_ack = 1'b0; done_clr = 1'b0;
    endtask

    task automatic do_miss();
        host_miss = 1'b1; step(); host_miss = 1'b0;
    endtask

    task automatic do_clear();
        buf_clear = 1'b1; step(); buf_clear = 1'b0;
    endtask

    task automatic do_dclr();
        done_clr = 1'b1; step(); done_clr = 1'b0;
    endtask

    // driver: loads the expected bytes, issues a token, drains
    task automatic send_expect(input string req);
        sbq.delete();
        foreach (model[i]) sbq.push_back(model[i]);
        tx_rd = 1'b1;
        do_token();
        for (int i = 0; i < 40 && sbq.size() != 0; i++) begin
            @(negedge clk); #1;
        end
        chk(sbq.size() == 0, req, sbq.size(), 0);
        step();
        tx_rd = 1'b0;
        @(negedge clk);
        chk(tx_valid == 1'b0, "R5 valid drops after last", tx_valid, 0);
        chk(pkt_armed == 1'b1, "R5 waits for handshake", pkt_armed, 1);
        step();
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        step(); step();
        @(negedge clk);
        chk(!tx_valid && !nak && !pkt_armed && !done_irq, "R1 reset state",
            {tx_valid, nak, pkt_armed, done_irq}, 0);
        rst_n = 1'b1;
        step();

        // R4: token with nothing locked
        do_token();
        @(negedge clk);
        chk(nak == 1'b1, "R4 nak raised", nak, 1);
        chk(tx_valid == 1'b0, "R4 no data on nak", tx_valid, 0);
        step();
        @(negedge clk);
        chk(nak == 1'b0, "R4 nak one cycle", nak, 0);
        step();

        // R3/R5: three-byte packet
        model.delete();
        wr_byte(8'hA1, 1); wr_byte(8'hB2, 1); wr_byte(8'hC3, 1);
        do_commit();
        @(negedge clk);
        chk(pkt_armed == 1'b1, "R3 armed after commit", pkt_armed, 1);
        chk(tx_len == 4'd3, "R2 length latched", tx_len, 3);
        step();
        send_expect("R5 three-byte packet drained");

        // R8: missed handshake, resend
        do_miss();
        @(negedge clk);
        chk(pkt_armed == 1'b1 && tx_len == 4'd3, "R8 kept after miss", tx_len, 3);
        step();
        send_expect("R8 resend drained");

        // R7: ack
        do_ack(0);
        @(negedge clk);
        chk(done_irq == 1'b1, "R7 flag set on ack", done_irq, 1);
        chk(pkt_armed == 1'b0, "R7 back to fill", pkt_armed, 0);
        step();

        // R11: write-one clear
        do_dclr();
        @(negedge clk);
        chk(done_irq == 1'b0, "R11 flag cleared", done_irq, 0);
        step();

        // R2: ten writes, only eight kept
        model.delete();
        for (int i = 0; i < 10; i++) wr_byte(8'h10 + 8'(i), i < 8);
        do_commit();
        @(negedge clk);
        chk(tx_len == 4'd8, "R2 overflow dropped", tx_len, 8);
        step();

        // R9: write and commit while armed are ignored
        wr_byte(8'hEE, 0);
        do_commit();
        @(negedge clk);
        chk(tx_len == 4'd8, "R9 length held while armed", tx_len, 8);
        step();
        send_expect("R9 locked packet unchanged");

        // R11: set wins over simultaneous clear
        do_ack(1);
        @(negedge clk);
        chk(done_irq == 1'b1, "R11 set beats clear", done_irq, 1);
        step();
        do_dclr();

        // R6: zero-length packet
        model.delete();
        do_commit();
        @(negedge clk);
        chk(tx_len == 4'd0 && pkt_armed, "R6 empty packet armed", tx_len, 0);
        step();
        tx_rd = 1'b1;
        do_token();
        @(negedge clk);
        chk(tx_valid == 1'b0 && pkt_armed == 1'b1, "R6 no data, waiting", tx_valid, 0);
        step();
        tx_rd = 1'b0;
        do_ack(0);
        @(negedge clk);
        chk(done_irq == 1'b1 && !pkt_armed, "R6 zero-length completes", done_irq, 1);
        step();

        // R10: clear while armed, flag untouched
        wr_byte(8'h5A, 0); wr_byte(8'h6B, 0);
        do_commit();
        do_clear();
        @(negedge clk);
        chk(pkt_armed == 1'b0, "R10 clear forces fill", pkt_armed, 0);
        chk(done_irq == 1'b1, "R10 flag unchanged", done_irq, 1);
        step();
        do_token();
        @(negedge clk);
        chk(nak == 1'b1, "R10 cleared packet gives nak", nak, 1);
        step();
        model.delete();
        wr_byte(8'h77, 1);
        do_commit();
        @(negedge clk);
        chk(tx_len == 4'd1, "R10 stored bytes discarded", tx_len, 1);
        step();
        send_expect("R10 fresh packet after clear");
        do_ack(0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule